// File: doc/BRIEF.md
# Refresh-offset compare watchdog

The block is a watchdog built on a free-running counter made of two bytes. It has one compare slot that holds two bytes: a deadline byte and an offset byte. When the watchdog is enabled, the deadline byte is compared for equality with the counter's high byte. A match produces a one-cycle reset request. Software holds the request off by refreshing. A refresh is a write of any value to the deadline byte, and it loads the deadline with the counter's current high byte plus the offset, wrapping. A refresh never clears the counter. It only moves the deadline forward by the offset.

The watchdog is active as the block leaves reset. While it is active, the counter is forced to run, and most configuration writes are locked out: counter bytes, clock-select, idle control and the module mode byte. The mode byte then reads as a fixed software-timer code. Clearing the enable bit returns full control to software. A sticky lock bit can make the enable bit impossible to clear until the next reset. The counter advances on a one-cycle `tick` taken from an external clock-source stage.

Top module: `wdc_wdog`

## Requirements
- R1: After reset, the watchdog enable reads 1 and every other register (counter bytes, control, mode, offset, deadline, lock) reads 0, and `rst_req` is 0.
- R2: While running, each cycle with `tick` high increments the 2·BYTE_W-bit counter by one. The low byte carries into the high byte, and the counter wraps to zero.
- R3: While enabled, a write of any data to address 5 (deadline) loads the deadline with (counter high byte + offset) modulo 2^BYTE_W, using the values from before that edge.
- R4: While enabled, the deadline is compared with the counter high byte in the cycle after the high byte advanced or after a refresh. Equality raises `rst_req` for one cycle at the next edge. An evaluation is dropped if a refresh is written in the same cycle.
- R5: While enabled, the counter runs whatever the run bit (bit 0 at address 2) holds. That bit reads back only the value software last wrote to it.
- R6: While enabled, writes to the counter bytes (address 0 low, 1 high) are ignored. While disabled, such a write loads that byte and the counter does not advance in that cycle.
- R7: While enabled, writes to the idle bit (bit 1 at address 2), the clock-select field (bits 4:2 at address 2) and the mode byte (address 3) are ignored. The mode byte then reads as the software-timer code MODE_SWT.
- R8: At address 6, bit 0 is the enable and bit 1 is the lock. Writing 1 to the lock sets it until reset. While the lock is set, a write cannot clear an active enable.
- R9: While disabled, `rst_req` stays 0, a write to the deadline stores the written data, and the counter runs only when the run bit is 1.
- R10: `rd_data` shows the register selected by `addr` one clock after it is presented. Address 7 reads zero and the offset is at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle count enable from the selected clock source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | BYTE_W | Write data |
| rd_data | output | BYTE_W | Registered read data |
| rst_req | output | 1 | One-cycle reset request on a deadline match |

## Verification
The bench builds the block with BYTE_W = 5, which makes the counter 10 bits wide. The counter then wraps after 1024 ticks, and the high byte advances every 32 ticks. This puts full counter wraps, repeated deadline matches and carry-into-high-byte cycles inside a few thousand clocks. A 5-bit byte still holds the three-bit clock-select field and the software-timer code, so every lockout rule stays visible through reads.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int ADDR_W = 3;
  localparam int CPS_W  = 3;
  // control byte fields
  localparam int CTL_RUN   = 0;
  localparam int CTL_IDLE  = 1;
  localparam int CTL_CPS_L = 2;
  // watchdog config byte fields
  localparam int WCF_EN    = 0;
  localparam int WCF_LOCK  = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CLO  = 3'd0,
    A_CHI  = 3'd1,
    A_CTRL = 3'd2,
    A_MODE = 3'd3,
    A_OFS  = 3'd4,
    A_DLN  = 3'd5,
    A_WCFG = 3'd6,
    A_NONE = 3'd7
  } wdc_addr_e;
endpackage

// File: rtl/wdc_counter.sv
module wdc_counter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              hi_evt
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] cnt_inc;
  assign cnt_inc = {cnt_hi, cnt_lo} + 1'b1;

  // R2 / R6: byte writes win over counting; carry from low byte flags the high-byte event
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      hi_evt <= 1'b0;
    end else begin
      hi_evt <= 1'b0;
      if (wr_lo) begin
        cnt_lo <= wdata;
      end else if (wr_hi) begin
        cnt_hi <= wdata;
      end else if (tick && run) begin
        {cnt_hi, cnt_lo} <= cnt_inc;
        hi_evt           <= &cnt_lo;
      end
    end
  end
endmodule

// File: rtl/wdc_cfg.sv
module wdc_cfg
  import wdc_pkg::*;
#(
  parameter int              BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] MODE_SWT = 'h09
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              wd_en,
  output logic              lock,
  output logic              run_sw,
  output logic              idle,
  output logic [CPS_W-1:0]  cps,
  output logic [BYTE_W-1:0] mode_eff
);
  logic [BYTE_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_en  <= 1'b1;          // R1: active out of reset
      lock   <= 1'b0;
      run_sw <= 1'b0;
      idle   <= 1'b0;
      cps    <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          run_sw <= wdata[CTL_RUN];                 // R5: stored, never gates counting while active
          if (!wd_en) begin                         // R7: frozen while active
            idle <= wdata[CTL_IDLE];
            cps  <= wdata[CTL_CPS_L +: CPS_W];
          end
        end
        A_MODE: if (!wd_en) mode_q <= wdata;        // R7
        A_WCFG: begin                               // R8
          lock  <= lock | wdata[WCF_LOCK];
          wd_en <= wdata[WCF_EN] | (lock & wd_en);
        end
        default: ;
      endcase
    end
  end

  // R7: slot behaves as a software timer while the watchdog owns it
  assign mode_eff = wd_en ? MODE_SWT : mode_q;
endmodule

// File: rtl/wdc_slot.sv
module wdc_slot #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wd_en,
  input  logic              wr_ofs,
  input  logic              wr_dln,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] cnt_hi,
  input  logic              hi_evt,
  output logic [BYTE_W-1:0] ofs,
  output logic [BYTE_W-1:0] dln,
  output logic              rst_req
);
  logic              refresh;
  logic              refr_evt;
  logic [BYTE_W-1:0] next_dln;
  logic              hit;

  assign refresh  = wr_dln & wd_en;
  assign next_dln = cnt_hi + ofs;                    // R3: wraps in BYTE_W bits
  // R4: evaluate only after a high-byte step or a refresh; a refresh this cycle wins
  assign hit      = wd_en & (hi_evt | refr_evt) & (dln == cnt_hi) & ~refresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs      <= '0;
      dln      <= '0;
      refr_evt <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      refr_evt <= refresh;
      rst_req  <= hit;
      if (wr_ofs) ofs <= wdata;
      if (wr_dln) dln <= wd_en ? next_dln : wdata;   // R9: plain store when disabled
    end
  end
endmodule

// File: rtl/wdc_wdog.sv
module wdc_wdog
  import wdc_pkg::*;
#(
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] MODE_SWT = 'h09
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rst_req
);
  logic              wd_en, lock, run_sw, idle, hi_evt;
  logic [CPS_W-1:0]  cps;
  logic [BYTE_W-1:0] mode_eff, cnt_lo, cnt_hi, ofs, dln;
  logic              wr_lo, wr_hi;
  logic [BYTE_W-1:0] rd_mux;

  // R6: counter bytes writable only with the watchdog off
  assign wr_lo = wr_en & (addr == A_CLO) & ~wd_en;
  assign wr_hi = wr_en & (addr == A_CHI) & ~wd_en;

  wdc_cfg #(.BYTE_W(BYTE_W), .MODE_SWT(MODE_SWT)) i_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wr_data),
    .wd_en(wd_en), .lock(lock), .run_sw(run_sw), .idle(idle), .cps(cps),
    .mode_eff(mode_eff)
  );

  wdc_counter #(.BYTE_W(BYTE_W)) i_cnt (
    .clk(clk), .rst(rst), .tick(tick), .run(run_sw | wd_en),   // R5: forced run
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wr_data),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .hi_evt(hi_evt)
  );

  wdc_slot #(.BYTE_W(BYTE_W)) i_slot (
    .clk(clk), .rst(rst), .wd_en(wd_en),
    .wr_ofs(wr_en & (addr == A_OFS)), .wr_dln(wr_en & (addr == A_DLN)),
    .wdata(wr_data), .cnt_hi(cnt_hi), .hi_evt(hi_evt),
    .ofs(ofs), .dln(dln), .rst_req(rst_req)
  );

  // R10: registered read port
  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CLO:  rd_mux = cnt_lo;
      A_CHI:  rd_mux = cnt_hi;
      A_CTRL: begin
        rd_mux[CTL_RUN]             = run_sw;
        rd_mux[CTL_IDLE]            = idle;
        rd_mux[CTL_CPS_L +: CPS_W]  = cps;
      end
      A_MODE: rd_mux = mode_eff;
      A_OFS:  rd_mux = ofs;
      A_DLN:  rd_mux = dln;
      A_WCFG: begin
        rd_mux[WCF_EN]   = wd_en;
        rd_mux[WCF_LOCK] = lock;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/wdc_wdog_chk.sv
module wdc_wdog_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic [2:0]        addr,
  input logic              rst_req,
  input logic              wd_en,
  input logic              lock,
  input logic              idle,
  input logic [2:0]        cps,
  input logic [BYTE_W-1:0] cnt_lo,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic [BYTE_W-1:0] ofs,
  input logic [BYTE_W-1:0] dln
);
  logic [BYTE_W-1:0]   sum_w;
  logic [2*BYTE_W-1:0] cnt_w, cnt_nx;
  assign sum_w  = cnt_hi + ofs;
  assign cnt_w  = {cnt_hi, cnt_lo};
  assign cnt_nx = cnt_w + 1'b1;

  a_r2_forced_count: assert property (@(posedge clk) disable iff (rst)
    (wd_en && tick) |=> (cnt_w == $past(cnt_nx)));

  a_r3_refresh_load: assert property (@(posedge clk) disable iff (rst)
    (wd_en && wr_en && addr == 3'd5) |=> (dln == $past(sum_w)));

  a_r4_req_on_match: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> ($past(wd_en) && $past(dln == cnt_hi)));

  a_r6_cnt_locked: assert property (@(posedge clk) disable iff (rst)
    (wd_en && wr_en && (addr == 3'd0 || addr == 3'd1) && !tick) |=> $stable(cnt_w));

  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    wd_en |=> ($stable(cps) && $stable(idle)));

  a_r8_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (lock && wd_en) |=> wd_en);

  a_r9_quiet_off: assert property (@(posedge clk) disable iff (rst)
    !wd_en |=> !rst_req);
endmodule

bind wdc_wdog wdc_wdog_chk #(.BYTE_W(BYTE_W)) i_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
  .rst_req(rst_req), .wd_en(wd_en), .lock(lock), .idle(idle), .cps(cps),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ofs(ofs), .dln(dln)
);

// File: tb/test_wdc_wdog.sv
module test_wdc_wdog;
  localparam int BW = 5;
  localparam logic [BW-1:0] SWT = 5'h09;

  logic          clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [BW-1:0] wr_data = '0;
  logic [BW-1:0] rd_data;
  logic          rst_req;

  always #10 clk = ~clk;   // 50 MHz

  wdc_wdog #(.BYTE_W(BW), .MODE_SWT(SWT)) i_wdc_wdog (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req)
  );

  int    nchk = 0, nerr = 0, obs_req = 0, mdl_req = 0;
  string ph = "R1";

  // reference model state
  logic [BW-1:0] m_lo, m_hi, m_ofs, m_dln, m_mode;
  logic          m_en, m_lock, m_run, m_idle, m_hev, m_rev;
  logic [2:0]    m_cps;
  logic [BW-1:0] exp_rd;
  logic          exp_rst;

  task automatic chk(input logic [BW-1:0] got, input logic [BW-1:0] exp, input string what);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s: got %0h expected %0h", ph, what, got, exp);
    end
  endtask

  function automatic logic [BW-1:0] rd_model(input logic [2:0] a);
    logic [BW-1:0] v = '0;
    case (a)
      3'd0: v = m_lo;
      3'd1: v = m_hi;
      3'd2: begin v[0] = m_run; v[1] = m_idle; v[4:2] = m_cps; end
      3'd3: v = m_en ? SWT : m_mode;
      3'd4: v = m_ofs;
      3'd5: v = m_dln;
      3'd6: begin v[0] = m_en; v[1] = m_lock; end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_reset();
    m_lo = '0; m_hi = '0; m_ofs = '0; m_dln = '0; m_mode = '0;
    m_en = 1'b1; m_lock = 1'b0; m_run = 1'b0; m_idle = 1'b0; m_cps = '0;
    m_hev = 1'b0; m_rev = 1'b0; exp_rd = '0; exp_rst = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; addr = '0; wr_data = '0; tick = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // one clock: check outputs of the previous edge, drive, advance the model
  task automatic step(input logic we, input logic [2:0] a, input logic [BW-1:0] d, input logic tk);
    logic refresh, cw, running;
    logic [2*BW-1:0] cnt;
    @(negedge clk);
    chk(rd_data, exp_rd, "R10 rd_data");
    chk({{(BW-1){1'b0}}, rst_req}, {{(BW-1){1'b0}}, exp_rst}, "R4 rst_req");
    if (rst_req) obs_req++;
    if (exp_rst) mdl_req++;
    wr_en = we; addr = a; wr_data = d; tick = tk;

    refresh = we && a == 3'd5 && m_en;
    exp_rst = m_en && (m_hev || m_rev) && (m_dln == m_hi) && !refresh;
    exp_rd  = rd_model(a);
    cw      = we && !m_en && (a == 3'd0 || a == 3'd1);
    running = m_run || m_en;
    m_rev   = refresh;
    m_hev   = !cw && tk && running && (m_lo == {BW{1'b1}});
    if (we && a == 3'd5) m_dln = m_en ? m_BW_add(m_hi, m_ofs) : d;
    if (cw) begin
      if (a == 3'd0) m_lo = d; else m_hi = d;
    end else if (tk && running) begin
      cnt = {m_hi, m_lo} + 1'b1;
      {m_hi, m_lo} = cnt;
    end
    if (we && a == 3'd4) m_ofs = d;
    if (we && a == 3'd2) begin
      m_run = d[0];
      if (!m_en) begin m_idle = d[1]; m_cps = d[4:2]; end
    end
    if (we && a == 3'd3 && !m_en) m_mode = d;
    if (we && a == 3'd6) begin
      m_en   = d[0] | (m_lock & m_en);
      m_lock = m_lock | d[1];
    end
  endtask

  function automatic logic [BW-1:0] m_BW_add(input logic [BW-1:0] x, input logic [BW-1:0] y);
    return x + y;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run hung, got 0 expected 1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int seed_dummy;
    model_reset();
    do_reset();

    ph = "R1";  // reset values through reads
    for (int a = 0; a < 8; a++) step(1'b0, 3'(a), '0, 1'b0);

    ph = "R2";  // forced counting with carry into high byte
    for (int i = 0; i < 70; i++) step(1'b0, 3'(i % 2), '0, 1'b1);

    ph = "R5";
    step(1'b1, 3'd2, 5'h00, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 3'd2, '0, 1'b1);
    step(1'b1, 3'd2, 5'h01, 1'b1);
    step(1'b0, 3'd2, '0, 1'b0);
    step(1'b1, 3'd2, 5'h00, 1'b0);

    ph = "R6";
    step(1'b1, 3'd0, 5'h1f, 1'b0);
    step(1'b1, 3'd1, 5'h1f, 1'b1);
    step(1'b0, 3'd0, '0, 1'b0);
    step(1'b0, 3'd1, '0, 1'b0);

    ph = "R7";
    step(1'b1, 3'd2, 5'h1e, 1'b0);
    step(1'b1, 3'd3, 5'h05, 1'b0);
    step(1'b0, 3'd2, '0, 1'b0);
    step(1'b0, 3'd3, '0, 1'b0);

    ph = "R3";
    step(1'b1, 3'd4, 5'h03, 1'b0);
    step(1'b1, 3'd5, 5'h1a, 1'b0);
    step(1'b0, 3'd5, '0, 1'b0);
    step(1'b0, 3'd4, '0, 1'b0);

    ph = "R4";  // let the deadline expire, then zero offset and back-to-back refreshes
    for (int i = 0; i < 300; i++) step(1'b0, 3'd1, '0, 1'b1);
    step(1'b1, 3'd4, 5'h00, 1'b0);
    step(1'b1, 3'd5, 5'h00, 1'b0);
    step(1'b1, 3'd5, 5'h11, 1'b0);
    step(1'b1, 3'd5, 5'h02, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 3'd5, '0, 1'b0);
    step(1'b1, 3'd4, 5'h01, 1'b0);
    for (int i = 0; i < 80; i++) step(1'b0, 3'd1, '0, 1'b1);

    ph = "R8";
    step(1'b1, 3'd6, 5'h03, 1'b0);
    step(1'b1, 3'd6, 5'h00, 1'b0);
    step(1'b0, 3'd6, '0, 1'b0);
    step(1'b0, 3'd6, '0, 1'b0);
    do_reset();

    ph = "R9";
    step(1'b1, 3'd6, 5'h00, 1'b0);
    step(1'b1, 3'd5, 5'h07, 1'b0);
    step(1'b1, 3'd0, 5'h1d, 1'b1);
    step(1'b1, 3'd1, 5'h07, 1'b0);
    for (int i = 0; i < 40; i++) step(1'b0, 3'(i % 2), '0, 1'b1);
    step(1'b1, 3'd2, 5'h1d, 1'b0);
    step(1'b1, 3'd3, 5'h12, 1'b0);
    step(1'b0, 3'd3, '0, 1'b0);
    for (int i = 0; i < 1100; i++) step(1'b0, 3'd1, '0, 1'b1);
    step(1'b1, 3'd6, 5'h01, 1'b0);
    step(1'b0, 3'd3, '0, 1'b0);
    step(1'b0, 3'd2, '0, 1'b0);

    ph = "R10 random";
    do_reset();
    seed_dummy = $urandom(32'd20240611);
    for (int i = 0; i < 4000; i++) begin
      logic we;
      logic [2:0] a;
      we = ($urandom % 5) == 0;
      a  = 3'($urandom % 8);
      step(we, a, BW'($urandom), 1'($urandom % 4 != 0));
    end
    step(1'b0, 3'd0, '0, 1'b0);
    step(1'b0, 3'd0, '0, 1'b0);

    ph = "R4 totals";
    nchk++;
    if (obs_req != mdl_req || mdl_req == 0) begin
      nerr++;
      $display("FAIL %s request count: got %0d expected %0d", ph, obs_req, mdl_req);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule